// File: doc/BRIEF.md
# Receive descriptor ring engine

This block moves received frames from a byte-wide stream into buffer memory under the control of a small ring of receive descriptors. Software hands a descriptor to the engine by arming it. Arming marks the descriptor empty and clears its length and status. Each arriving frame goes into the buffer of the current descriptor. When the frame's last byte arrives, the engine returns the descriptor to software with the byte count and the error flags, then moves to the next descriptor. After the last descriptor it starts again at the first. The stream carries the frame check sequence, so the recorded length includes those four trailing bytes. Consumers subtract four to get the payload size.

Each descriptor has a fixed buffer in a flat byte memory: buffer `i` starts at `i * BUF_LEN`. The engine has no ready signal and never stalls the stream. A frame the engine cannot take is read in and discarded. If a frame starts while the current descriptor still belongs to software, the engine raises a busy event and enters a halted state. While halted it drops every frame until a clear-halt command arrives.

A graceful stop request lets a frame that is being stored finish. Once no frame is being stored, the engine reports stop-complete. Frames that start while the request is held are dropped.

Top module: `rxr_engine`

## Requirements
- R1: After reset every descriptor belongs to software (empty 0, length 0, status 0), busy, halted and stop-complete are low, and the first frame goes to descriptor 0. Arming a descriptor sets empty and zeroes its length and status.
- R2: Byte `k` of a stored frame is written at buffer address `{desc_index, k}` on `buf_*` one cycle after it is accepted. In the cycle after the last byte, that descriptor shows empty 0 and a length equal to the full byte count, FCS included.
- R3: If `in_err` is high on any byte of a stored frame, status bit 0 (frame error) of its descriptor is set; otherwise that bit is 0.
- R4: `rd_wrap` is 1 only for index DEPTH-1. The frame after the one stored there goes to descriptor 0.
- R5: A frame longer than BUF_LEN has only its first BUF_LEN bytes written and reports length BUF_LEN with status bit 1 (truncated) set. Shorter frames leave bit 1 at 0.
- R6: If a frame starts while the current descriptor is not empty, the whole frame is dropped with no buffer writes and no descriptor change, and busy and halted rise. While halted, all frames are dropped. A `clr_halt` pulse lets frames starting from the next cycle be stored.
- R7: `busy_clr` clears busy (write-one-to-clear) and leaves halted unchanged. When a new busy event and `busy_clr` fall in the same cycle, busy stays set.
- R8: With `stop_req` high, a frame being stored completes normally, and `stop_done` rises in the cycle after its last byte (or one cycle after the request when idle). Frames starting while `stop_req` is high are dropped without a busy event. `stop_done` falls one cycle after `stop_req` falls.
- R9: Dropped frames are consumed at stream rate. A frame whose first byte directly follows the last byte of a dropped frame is stored normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Final byte of the frame |
| in_err | input | 1 | Error mark for the frame (any byte) |
| arm_vld | input | 1 | Give descriptor `arm_idx` to the engine |
| arm_idx | input | IDX_W (2) | Descriptor to arm |
| rd_idx | input | IDX_W (2) | Descriptor to inspect |
| rd_empty | output | 1 | Inspected descriptor is owned by the engine |
| rd_wrap | output | 1 | Inspected descriptor is the last in the ring |
| rd_len | output | LEN_W (7) | Stored length, FCS included |
| rd_stat | output | 2 | Bit 0 frame error, bit 1 truncated |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | AW (8) | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| clr_halt | input | 1 | Clear-receive-halt command |
| busy_clr | input | 1 | Write-one-to-clear of the busy event |
| busy | output | 1 | Busy event (frame arrived with no empty descriptor) |
| halted | output | 1 | Reception halted |
| stop_req | input | 1 | Graceful stop request |
| stop_done | output | 1 | Stop complete |

## Verification
Two of the block's actions can fall in the same cycle: raising a new busy event and clearing busy with the write-one-to-clear. The bench starts a frame against a software-owned descriptor and pulses `busy_clr` on that frame's first byte. Busy must still read 1 afterwards, and a later `busy_clr` on its own must clear it while halted stays high. The same approach covers the graceful stop. The request rises while a frame is being stored, and `stop_done` must stay low on every remaining byte and rise only in the cycle after the last byte. The stop is then released on the same edge as a new frame's first byte, which checks that the frame is stored without a gap.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

   typedef struct packed {
      logic trunc;   // bit 1
      logic err;     // bit 0
   } rxr_stat_t;

   typedef enum logic [1:0] {
      M_IDLE  = 2'd0,
      M_STORE = 2'd1,
      M_DROP  = 2'd2
   } rxr_mode_e;

endpackage

// File: rtl/rxr_desc_ring.sv
module rxr_desc_ring
   import rxr_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int IDX_W = 2,
   parameter int LEN_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_vld,
   input  logic [IDX_W-1:0] arm_idx,
   input  logic             wb_vld,
   input  logic [IDX_W-1:0] wb_idx,
   input  logic [LEN_W-1:0] wb_len,
   input  rxr_stat_t        wb_stat,
   input  logic [IDX_W-1:0] cur_idx,
   output logic             cur_empty,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_empty,
   output logic [LEN_W-1:0] rd_len,
   output rxr_stat_t        rd_stat
);

   logic [DEPTH-1:0] empty_q;
   logic [LEN_W-1:0] len_q  [DEPTH];
   rxr_stat_t        stat_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_desc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            empty_q[g] <= 1'b0;
            len_q[g]   <= '0;
            stat_q[g]  <= '0;
         end else if (wb_vld && wb_idx == IDX_W'(g)) begin
            empty_q[g] <= 1'b0;
            len_q[g]   <= wb_len;
            stat_q[g]  <= wb_stat;
         end else if (arm_vld && arm_idx == IDX_W'(g)) begin
            empty_q[g] <= 1'b1;
            len_q[g]   <= '0;
            stat_q[g]  <= '0;
         end
      end
   end

   assign cur_empty = empty_q[cur_idx];
   assign rd_empty  = empty_q[rd_idx];
   assign rd_len    = len_q[rd_idx];
   assign rd_stat   = stat_q[rd_idx];

   AST_WB_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      wb_vld |-> empty_q[wb_idx]);  // R2

endmodule

// File: rtl/rxr_frame_ctl.sv
module rxr_frame_ctl
   import rxr_pkg::*;
#(
   parameter int DEPTH   = 4,
   parameter int BUF_LEN = 64,
   parameter int IDX_W   = 2,
   parameter int OFF_W   = 6,
   parameter int LEN_W   = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [7:0]             in_data,
   input  logic                   in_last,
   input  logic                   in_err,
   input  logic                   cur_empty,
   output logic [IDX_W-1:0]       cur_idx,
   output logic                   wb_vld,
   output logic [LEN_W-1:0]       wb_len,
   output rxr_stat_t              wb_stat,
   output logic                   buf_we,
   output logic [IDX_W+OFF_W-1:0] buf_addr,
   output logic [7:0]             buf_wdata,
   input  logic                   clr_halt,
   input  logic                   busy_clr,
   output logic                   busy,
   output logic                   halted,
   input  logic                   stop_req,
   output logic                   stop_done
);

   localparam logic [LEN_W-1:0] CAP  = LEN_W'(BUF_LEN);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   rxr_mode_e        mode_q, mode_nx;
   logic [LEN_W-1:0] cnt_q, cnt_base, cnt_next;
   logic             err_q, trunc_q, err_now, trunc_now;
   logic [IDX_W-1:0] cur_q;
   logic             busy_q, halt_q, stop_q;
   logic             sof, start_ok, accept, refuse, storing, room, finish;

   always_comb begin
      sof       = in_valid && (mode_q == M_IDLE);
      start_ok  = sof && !stop_req && !halt_q;
      accept    = start_ok && cur_empty;
      refuse    = start_ok && !cur_empty;
      storing   = accept || (in_valid && mode_q == M_STORE);
      cnt_base  = accept ? '0 : cnt_q;
      room      = cnt_base < CAP;
      cnt_next  = cnt_base + LEN_W'(room);
      err_now   = (accept ? 1'b0 : err_q) | in_err;
      trunc_now = (accept ? 1'b0 : trunc_q) | !room;
      finish    = storing && in_last;

      mode_nx = mode_q;
      unique case (mode_q)
         M_IDLE:  if (sof && !in_last) mode_nx = accept ? M_STORE : M_DROP;
         M_STORE: if (in_valid && in_last) mode_nx = M_IDLE;
         M_DROP:  if (in_valid && in_last) mode_nx = M_IDLE;
         default: mode_nx = M_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= M_IDLE;
         cnt_q     <= '0;
         err_q     <= 1'b0;
         trunc_q   <= 1'b0;
         cur_q     <= '0;
         busy_q    <= 1'b0;
         halt_q    <= 1'b0;
         stop_q    <= 1'b0;
         buf_we    <= 1'b0;
         buf_addr  <= '0;
         buf_wdata <= '0;
      end else begin
         mode_q <= mode_nx;
         if (storing) begin
            cnt_q   <= cnt_next;
            err_q   <= err_now;
            trunc_q <= trunc_now;
         end
         if (finish) cur_q <= (cur_q == LAST) ? '0 : cur_q + IDX_W'(1);
         if (refuse)        busy_q <= 1'b1;
         else if (busy_clr) busy_q <= 1'b0;
         if (refuse)        halt_q <= 1'b1;
         else if (clr_halt) halt_q <= 1'b0;
         stop_q    <= stop_req && (mode_nx != M_STORE);
         buf_we    <= storing && room;
         buf_addr  <= {cur_q, cnt_base[OFF_W-1:0]};
         buf_wdata <= in_data;
      end
   end

   assign cur_idx   = cur_q;
   assign wb_vld    = finish;
   assign wb_len    = cnt_next;
   assign wb_stat   = '{trunc: trunc_now, err: err_now};
   assign busy      = busy_q;
   assign halted    = halt_q;
   assign stop_done = stop_q;

   AST_BUSY_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> halt_q);  // R6
   AST_HALT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |-> !wb_vld);  // R6
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_vld && cur_q == LAST) |=> (cur_q == '0));  // R4
   AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_vld |-> (wb_len != '0 && wb_len <= CAP));  // R5
   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && stop_req) |=> !buf_we);  // R8

endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
   import rxr_pkg::*;
#(
   parameter int DEPTH   = 4,
   parameter int BUF_LEN = 64,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int OFF_W  = $clog2(BUF_LEN),
   localparam int LEN_W  = $clog2(BUF_LEN + 1),
   localparam int AW     = IDX_W + OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   input  logic             in_last,
   input  logic             in_err,
   input  logic             arm_vld,
   input  logic [IDX_W-1:0] arm_idx,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_empty,
   output logic             rd_wrap,
   output logic [LEN_W-1:0] rd_len,
   output logic [1:0]       rd_stat,
   output logic             buf_we,
   output logic [AW-1:0]    buf_addr,
   output logic [7:0]       buf_wdata,
   input  logic             clr_halt,
   input  logic             busy_clr,
   output logic             busy,
   output logic             halted,
   input  logic             stop_req,
   output logic             stop_done
);

   if (DEPTH < 2) begin : g_chk_depth
      $error("rxr_engine: DEPTH must be at least 2");
   end
   if ((1 << IDX_W) != DEPTH) begin : g_chk_depth_pow2
      $error("rxr_engine: DEPTH must be a power of two");
   end
   if (BUF_LEN < 4 || (1 << OFF_W) != BUF_LEN) begin : g_chk_buf
      $error("rxr_engine: BUF_LEN must be a power of two of at least 4");
   end

   logic             cur_empty, wb_vld;
   logic [IDX_W-1:0] cur_idx;
   logic [LEN_W-1:0] wb_len;
   rxr_stat_t        wb_stat, rd_stat_s;

   rxr_frame_ctl #(
      .DEPTH(DEPTH), .BUF_LEN(BUF_LEN), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEN_W(LEN_W)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
      .cur_empty(cur_empty), .cur_idx(cur_idx),
      .wb_vld(wb_vld), .wb_len(wb_len), .wb_stat(wb_stat),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
      .clr_halt(clr_halt), .busy_clr(busy_clr), .busy(busy), .halted(halted),
      .stop_req(stop_req), .stop_done(stop_done)
   );

   rxr_desc_ring #(
      .DEPTH(DEPTH), .IDX_W(IDX_W), .LEN_W(LEN_W)
   ) u_ring (
      .clk(clk), .rst_n(rst_n),
      .arm_vld(arm_vld), .arm_idx(arm_idx),
      .wb_vld(wb_vld), .wb_idx(cur_idx), .wb_len(wb_len), .wb_stat(wb_stat),
      .cur_idx(cur_idx), .cur_empty(cur_empty),
      .rd_idx(rd_idx), .rd_empty(rd_empty), .rd_len(rd_len), .rd_stat(rd_stat_s)
   );

   assign rd_wrap = (rd_idx == IDX_W'(DEPTH - 1));
   assign rd_stat = rd_stat_s;

endmodule

// File: tb/sim_rxr_engine.sv
module sim_rxr_engine;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 0, in_last = 0, in_err = 0;
   logic [7:0] in_data = '0;
   logic       arm_vld = 0;
   logic [1:0] arm_idx = '0, rd_idx = '0;
   logic       rd_empty, rd_wrap, buf_we, busy, halted, stop_done;
   logic [6:0] rd_len;
   logic [1:0] rd_stat;
   logic [7:0] buf_addr, buf_wdata;
   logic       clr_halt = 0, busy_clr = 0, stop_req = 0;

   int total = 0, bad = 0, wr_cnt = 0;
   bit done = 0;
   logic [7:0] bmem [256];

   always #5 clk = ~clk;

   rxr_engine u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .in_err(in_err), .arm_vld(arm_vld), .arm_idx(arm_idx),
      .rd_idx(rd_idx), .rd_empty(rd_empty), .rd_wrap(rd_wrap), .rd_len(rd_len),
      .rd_stat(rd_stat), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
      .clr_halt(clr_halt), .busy_clr(busy_clr), .busy(busy), .halted(halted),
      .stop_req(stop_req), .stop_done(stop_done)
   );

   always @(negedge clk) if (rst_n && buf_we) begin
      bmem[buf_addr] = buf_wdata;
      wr_cnt++;
   end

   task automatic check(string req, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic arm(int idx);
      @(negedge clk); arm_vld = 1; arm_idx = 2'(idx);
      @(negedge clk); arm_vld = 0;
   endtask

   task automatic send_frame(int n, bit err, int seed);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1; in_data = 8'(seed + i);
         in_last = (i == n - 1); in_err = err && (i == 0);
      end
   endtask

   task automatic idle1();
      @(negedge clk); in_valid = 0; in_last = 0; in_err = 0; busy_clr = 0; clr_halt = 0;
      #1;
   endtask

   task automatic desc_chk(string req, int idx, int e, int len, int st);
      rd_idx = 2'(idx); #1;
      check(req, "empty", int'(rd_empty), e);
      check(req, "length", int'(rd_len), len);
      check(req, "status", int'(rd_stat), st);
   endtask

   task automatic t_reset();
      #1;
      check("R1", "busy", int'(busy), 0);
      check("R1", "halted", int'(halted), 0);
      check("R1", "stop_done", int'(stop_done), 0);
      for (int i = 0; i < 4; i++) desc_chk("R1", i, 0, 0, 0);
      for (int i = 0; i < 4; i++) arm(i);
      #1;
      for (int i = 0; i < 4; i++) desc_chk("R1", i, 1, 0, 0);
   endtask

   task automatic t_basic();
      int w0;
      w0 = wr_cnt;
      send_frame(10, 0, 8'h10); idle1();
      desc_chk("R2", 0, 0, 10, 0);
      check("R2", "writes", wr_cnt - w0, 10);
      check("R2", "byte0", int'(bmem[0]), 8'h10);
      check("R2", "byte9", int'(bmem[9]), 8'h19);
      send_frame(5, 1, 8'h20); idle1();
      desc_chk("R3", 1, 0, 5, 1);
      check("R3", "byte64", int'(bmem[64]), 8'h20);
   endtask

   task automatic t_trunc();
      int w0;
      w0 = wr_cnt;
      send_frame(70, 0, 8'h40); idle1();
      desc_chk("R5", 2, 0, 64, 2);
      check("R5", "writes", wr_cnt - w0, 64);
      check("R5", "last byte", int'(bmem[191]), 8'h7F);
      check("R5", "next buffer untouched", int'(bmem[192]), 8'hEE);
   endtask

   task automatic t_wrap();
      send_frame(4, 0, 8'hA0); idle1();
      desc_chk("R4", 3, 0, 4, 0);
      rd_idx = 2'd3; #1; check("R4", "wrap on last", int'(rd_wrap), 1);
      rd_idx = 2'd0; #1; check("R4", "wrap on first", int'(rd_wrap), 0);
      arm(0);
      send_frame(3, 0, 8'h33); idle1();
      desc_chk("R4", 0, 0, 3, 0);
      check("R4", "byte0 after wrap", int'(bmem[0]), 8'h33);
   endtask

   task automatic t_busy();
      int w0;
      w0 = wr_cnt;
      // descriptor 1 still belongs to software; busy_clr on the first byte
      @(negedge clk); in_valid = 1; in_data = 8'h55; in_last = 0; busy_clr = 1;
      @(negedge clk); busy_clr = 0; in_data = 8'h56; in_last = 1;
      idle1();
      check("R7", "busy set wins over clear", int'(busy), 1);
      check("R6", "halted", int'(halted), 1);
      check("R6", "writes", wr_cnt - w0, 0);
      desc_chk("R6", 1, 0, 5, 1);
      @(negedge clk); busy_clr = 1;
      idle1();
      check("R7", "busy cleared", int'(busy), 0);
      check("R7", "halt kept", int'(halted), 1);
      arm(1);
      send_frame(4, 0, 8'h77); idle1();
      desc_chk("R6", 1, 1, 0, 0);
      check("R6", "writes while halted", wr_cnt - w0, 0);
      @(negedge clk); clr_halt = 1;
      idle1();
      check("R6", "halt cleared", int'(halted), 0);
      send_frame(6, 0, 8'h60); idle1();
      desc_chk("R6", 1, 0, 6, 0);
      check("R6", "byte after resume", int'(bmem[64]), 8'h60);
   endtask

   task automatic t_stop();
      int w0;
      arm(2); arm(3);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         in_valid = 1; in_data = 8'(8'hC0 + i); in_last = (i == 5);
         if (i == 2) stop_req = 1;
         #1;
         if (i >= 3) check("R8", "stop_done during frame", int'(stop_done), 0);
      end
      idle1();
      check("R8", "stop_done after last byte", int'(stop_done), 1);
      desc_chk("R8", 2, 0, 6, 0);
      check("R8", "last byte stored", int'(bmem[133]), 8'hC5);
      w0 = wr_cnt;
      send_frame(5, 0, 8'h90);
      stop_req = 0;
      send_frame(7, 0, 8'hD0);
      idle1();
      check("R8", "no busy on stop drop", int'(busy), 0);
      check("R8", "stop_done released", int'(stop_done), 0);
      check("R9", "writes", wr_cnt - w0, 7);
      desc_chk("R9", 3, 0, 7, 0);
      check("R9", "back-to-back byte0", int'(bmem[192]), 8'hD0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) bmem[i] = 8'hEE;
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_basic();
      t_trunc();
      t_wrap();
      t_busy();
      t_stop();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule